// File: doc/BRIEF.md
# Looping Waveform Playback Buffer

This block holds a table of sample words and replays it without end towards a two-channel digital-to-analog converter. Each stored word is 32 bits wide and carries one sample for each channel. The table is written from an AXI4-Stream input, normally fed by a memory-to-stream DMA engine. Writing is allowed only while playback is halted.

Once the run control is raised, a read address walks through the first `cfg_len` entries. After the last entry it returns to zero, so the stored waveform repeats. Lowering the run control freezes the read position and the outputs, and the next run carries on from the following entry. A separate rewind pulse sends the read position back to the first entry. A divider holds each sample for several clocks, which lowers the output rate below one sample per clock.

Top module: `wave_loop_player`

## Requirements
- R1: Each presented sample splits the stored word into two channels. `dac_a` carries bits [31:18] and `dac_b` carries bits [15:2], which is the upper 14 bits of each 16-bit half.
- R2: While `gen_en` is low, `s_axis_tready` is high. Every beat with `s_axis_tvalid` high writes its word at the write pointer, and the pointer then advances by one. After a beat with `s_axis_tlast` high, the pointer restarts at 0. While `gen_en` is high, `s_axis_tready` is low and beats leave the table unchanged.
- R3: While running, each new sample comes from the entry after the previous one. After entry `cfg_len`-1 the next sample comes from entry 0.
- R4: When `gen_en` falls, `dac_a`, `dac_b` and `play_addr` keep their values. The first sample after `gen_en` rises again is the entry following the last one presented.
- R5: A one-cycle `addr_clr` pulse sets the read position to 0 and takes priority over advancing in that cycle. The next sample presented comes from entry 0.
- R6: With `cfg_len` set to 0 or 1, every sample comes from entry 0.
- R7: A `cfg_div` value of 0 or 1 gives a new sample on every running clock. A value N of 2 or more gives one new sample every N running clocks. The first sample after a start or a rewind is not delayed.
- R8: `dac_valid` is high for exactly one cycle for each new sample, and only while running. The sample appears on the clock edge that follows the cycle in which `gen_en` is high and a sample is due. `play_addr` gives the entry of the sample on the outputs.
- R9: After reset, `dac_a`, `dac_b`, `play_addr` and `dac_valid` are 0, and both the read position and the write pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_axis_tdata | input | 32 | Stream word: channel A in the upper half, channel B in the lower half |
| s_axis_tvalid | input | 1 | Stream beat valid |
| s_axis_tready | output | 1 | Stream ready; high while playback is halted |
| s_axis_tlast | input | 1 | Last beat of a load; the write pointer restarts at 0 after it |
| gen_en | input | 1 | Run control: high plays, low pauses |
| addr_clr | input | 1 | Rewind pulse for the read position |
| cfg_len | input | ADDR_W (10) | Number of table entries played per loop |
| cfg_div | input | DIV_W (16) | Clocks per sample; 0 and 1 both mean one clock |
| dac_a | output | DAC_W (14) | Channel A converter code |
| dac_b | output | DAC_W (14) | Channel B converter code |
| dac_valid | output | 1 | One-cycle strobe for each new sample |
| play_addr | output | ADDR_W (10) | Table entry of the sample being presented |

## Verification
The checker watches several properties on every cycle. Stream ready must be low while running. No strobe may appear without a run in the previous cycle. Both channel codes must hold between strobes. Back-to-back strobes must step the entry by one or wrap to zero, and they are only allowed when the divider was 0 or 1. The first sample after a rewind must come from entry 0.

Some behaviours depend on the stored contents and on long histories, so only the bench scenarios can show them. These include the exact split of each word between the two channels, and that loop restarts follow the programmed length. They also include continuing from the right entry after a pause, the effect of a short load ended by `tlast` followed by further beats, and the spacing of strobes for a divider of 2 or more. The bench covers these with a reference model that it compares against the outputs on every clock.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
   localparam int unsigned CH_COUNT = 2;

   typedef enum logic {
      PLAY_STOPPED = 1'b0,
      PLAY_RUNNING = 1'b1
   } play_mode_e;
endpackage

// File: rtl/wlp_sample_ram.sv
module wlp_sample_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // read register keeps the last fetched word while no read is issued
   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/wlp_stream_loader.sv
module wlp_stream_loader #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tvalid,
   input  logic              tlast,
   output logic              tready,
   output logic              we,
   output logic [ADDR_W-1:0] waddr
);
   logic [ADDR_W-1:0] wp;

   assign tready = !run;
   assign we     = tready && tvalid;
   assign waddr  = wp;

   always_ff @(posedge clk) begin
      if (!rst_n)      wp <= '0;
      else if (we) begin
         if (tlast)    wp <= '0;
         else          wp <= wp + 1'b1;
      end
   end
endmodule

// File: rtl/wlp_rate_div.sv
module wlp_rate_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   import wlp_pkg::*;

   logic [DIV_W-1:0] hold_cnt;
   play_mode_e       mode;
   logic             no_div;

   assign mode   = run ? PLAY_RUNNING : PLAY_STOPPED;
   assign no_div = (div <= DIV_W'(1));
   assign tick   = (mode == PLAY_RUNNING) && !clr && (hold_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                                hold_cnt <= '0;
      else if (clr || (mode == PLAY_STOPPED))    hold_cnt <= '0;
      else if (tick)                             hold_cnt <= no_div ? '0 : div - 1'b1;
      else                                       hold_cnt <= hold_cnt - 1'b1;
   end
endmodule

// File: rtl/wlp_play_addr.sv
module wlp_play_addr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              clr,
   input  logic [ADDR_W-1:0] len,
   output logic [ADDR_W-1:0] addr
);
   logic short_len;
   logic at_end;

   assign short_len = (len <= ADDR_W'(1));
   assign at_end    = short_len || (addr >= len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)      addr <= '0;
      else if (clr)    addr <= '0;
      else if (tick)   addr <= at_end ? '0 : addr + 1'b1;
   end
endmodule

// File: rtl/wave_loop_player.sv
module wave_loop_player #(
   parameter int ADDR_W = 10,
   parameter int HALF_W = 16,
   parameter int DAC_W  = 14,
   parameter int DIV_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*HALF_W-1:0]   s_axis_tdata,
   input  logic                  s_axis_tvalid,
   output logic                  s_axis_tready,
   input  logic                  s_axis_tlast,
   input  logic                  gen_en,
   input  logic                  addr_clr,
   input  logic [ADDR_W-1:0]     cfg_len,
   input  logic [DIV_W-1:0]      cfg_div,
   output logic [DAC_W-1:0]      dac_a,
   output logic [DAC_W-1:0]      dac_b,
   output logic                  dac_valid,
   output logic [ADDR_W-1:0]     play_addr
);
   localparam int WORD_W = int'(wlp_pkg::CH_COUNT) * HALF_W;

   if (ADDR_W < 2 || ADDR_W > 14) begin : g_bad_addr
      $fatal(1, "ADDR_W must lie in 2..14");
   end
   if (DAC_W < 1 || DAC_W > HALF_W) begin : g_bad_dac
      $fatal(1, "DAC_W must lie in 1..HALF_W");
   end
   if (DIV_W < 1) begin : g_bad_div
      $fatal(1, "DIV_W must be at least 1");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic              tick;
   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_word;
   logic              valid_q;
   logic [ADDR_W-1:0] shown_q;

   wlp_stream_loader #(.ADDR_W(ADDR_W)) u_loader (
      .clk(clk), .rst_n(rst_n), .run(gen_en),
      .tvalid(s_axis_tvalid), .tlast(s_axis_tlast), .tready(s_axis_tready),
      .we(wr_en), .waddr(wr_addr)
   );

   wlp_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(gen_en), .clr(addr_clr),
      .div(cfg_div), .tick(tick)
   );

   wlp_play_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(addr_clr),
      .len(cfg_len), .addr(rd_addr)
   );

   wlp_sample_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
      .wdata(s_axis_tdata), .re(tick), .raddr(rd_addr), .rdata(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         shown_q <= '0;
      end else begin
         valid_q <= tick;
         if (tick) shown_q <= rd_addr;
      end
   end

   // channel A in the upper half, channel B in the lower half; codes are MSB-aligned
   assign dac_a     = rd_word[WORD_W-1 -: DAC_W];
   assign dac_b     = rd_word[HALF_W-1 -: DAC_W];
   assign dac_valid = valid_q;
   assign play_addr = shown_q;
endmodule

// File: rtl/wlp_checker.sv
module wlp_checker #(
   parameter int ADDR_W = 10,
   parameter int DAC_W  = 14,
   parameter int DIV_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gen_en,
   input logic              addr_clr,
   input logic              s_axis_tready,
   input logic [DIV_W-1:0]  cfg_div,
   input logic [DAC_W-1:0]  dac_a,
   input logic [DAC_W-1:0]  dac_b,
   input logic              dac_valid,
   input logic [ADDR_W-1:0] play_addr
);
   p_tready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |-> !s_axis_tready);

   p_valid_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dac_valid |-> $past(gen_en));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_valid |-> ($stable(dac_a) && $stable(dac_b)));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_valid && $past(dac_valid)) |->
         ((play_addr == ADDR_W'($past(play_addr) + 1'b1)) || (play_addr == '0)));

   p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_valid && $past(addr_clr, 2) && !$past(addr_clr)) |-> (play_addr == '0));

   p_div_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_valid && $past(dac_valid)) |-> ($past(cfg_div, 2) <= DIV_W'(1)));
endmodule

bind wave_loop_player wlp_checker #(.ADDR_W(ADDR_W), .DAC_W(DAC_W), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .addr_clr(addr_clr),
   .s_axis_tready(s_axis_tready), .cfg_div(cfg_div), .dac_a(dac_a), .dac_b(dac_b),
   .dac_valid(dac_valid), .play_addr(play_addr)
);

// File: tb/tb_wave_loop_player.sv
`timescale 1ns/1ps
module tb_wave_loop_player;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   tdata = '0;
   logic          tvalid = 1'b0;
   logic          tready;
   logic          tlast = 1'b0;
   logic          gen_en = 1'b0;
   logic          addr_clr = 1'b0;
   logic [AW-1:0] cfg_len = '0;
   logic [DW-1:0] cfg_div = '0;
   logic [13:0]   dac_a, dac_b;
   logic          dac_valid;
   logic [AW-1:0] play_addr;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wave_loop_player dut (
      .clk(clk), .rst_n(rst_n), .s_axis_tdata(tdata), .s_axis_tvalid(tvalid),
      .s_axis_tready(tready), .s_axis_tlast(tlast), .gen_en(gen_en),
      .addr_clr(addr_clr), .cfg_len(cfg_len), .cfg_div(cfg_div),
      .dac_a(dac_a), .dac_b(dac_b), .dac_valid(dac_valid), .play_addr(play_addr)
   );

   // behavioural reference model
   logic [31:0] m_mem [int];
   int   m_wp = 0, m_rd = 0, m_cnt = 0, m_shown = 0;
   logic [31:0] m_word = '0;
   bit   m_valid = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wp = 0; m_rd = 0; m_cnt = 0; m_shown = 0; m_word = '0; m_valid = 0;
      end else begin
         m_valid = 0;
         if (!gen_en && tvalid) begin
            m_mem[m_wp] = tdata;
            m_wp = tlast ? 0 : (m_wp + 1) % (1 << AW);
         end
         if (addr_clr) begin
            m_rd = 0; m_cnt = 0;
         end else if (!gen_en) begin
            m_cnt = 0;
         end else if (m_cnt == 0) begin
            m_word  = m_mem.exists(m_rd) ? m_mem[m_rd] : 32'h0;
            m_valid = 1;
            m_shown = m_rd;
            m_rd    = (cfg_len <= 1 || m_rd >= int'(cfg_len) - 1) ? 0 : m_rd + 1;
            m_cnt   = (cfg_div <= 1) ? 0 : int'(cfg_div) - 1;
         end else begin
            m_cnt = m_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison of registered outputs
   always @(negedge clk) begin
      if (rst_n) begin
         chk(dac_valid == m_valid, "R8 strobe", dac_valid, m_valid);
         chk(play_addr == AW'(m_shown), "R3 entry", play_addr, m_shown);
         chk(dac_a == m_word[31:18], "R1 chan A", dac_a, m_word[31:18]);
         chk(dac_b == m_word[15:2], "R1 chan B", dac_b, m_word[15:2]);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] pat(input int i, input int salt);
      return (32'(i) * 32'h0123_4457) ^ 32'hA5A5_0F0F ^ 32'(salt);
   endfunction

   task automatic push(input logic [31:0] w, input bit last);
      tdata = w; tvalid = 1'b1; tlast = last;
      step(1);
      tvalid = 1'b0; tlast = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int p;
      int strobes;
      logic [13:0] held_a;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R9 reset state
      chk(dac_valid == 0 && dac_a == 0 && dac_b == 0 && play_addr == 0, "R9 reset", dac_a, 0);
      chk(tready == 1, "R2 ready when halted", tready, 1);

      for (int i = 0; i < 8; i++) push(pat(i, 0), i == 7);

      cfg_len = 5; cfg_div = 0; gen_en = 1;
      step(1);
      chk(tready == 0, "R2 ready low while running", tready, 0);
      step(13);
      p = play_addr; held_a = dac_a;
      gen_en = 0;
      step(4);
      chk(play_addr == AW'(p) && dac_a == held_a && !dac_valid, "R4 hold on stop", play_addr, p);
      gen_en = 1;
      step(1);
      chk(play_addr == AW'((p + 1) % 5), "R4 resume continues", play_addr, (p + 1) % 5);
      step(2);
      gen_en = 0;

      addr_clr = 1; step(1); addr_clr = 0; gen_en = 1; step(1);
      chk(dac_valid && play_addr == 0, "R5 rewind to entry 0", play_addr, 0);
      chk(dac_a == pat(0, 0)[31:18], "R5 first word after rewind", dac_a, pat(0, 0)[31:18]);
      step(5);

      gen_en = 0; step(1);
      cfg_div = 3; gen_en = 1;
      strobes = 0;
      for (int i = 0; i < 12; i++) begin step(1); if (dac_valid) strobes++; end
      chk(strobes == 4, "R7 divide by 3", strobes, 4);
      gen_en = 0; cfg_div = 1; step(1);
      gen_en = 1; strobes = 0;
      for (int i = 0; i < 6; i++) begin step(1); if (dac_valid) strobes++; end
      chk(strobes == 6, "R7 divide value 1", strobes, 6);

      gen_en = 0; cfg_div = 0; cfg_len = 1; addr_clr = 1; step(1); addr_clr = 0;
      gen_en = 1; step(1);
      for (int i = 0; i < 4; i++) begin
         chk(play_addr == 0 && dac_valid, "R6 length one", play_addr, 0);
         step(1);
      end
      cfg_len = 0;
      for (int i = 0; i < 3; i++) begin
         step(1);
         chk(play_addr == 0, "R6 length zero", play_addr, 0);
      end

      cfg_len = 8;
      tdata = 32'hDEAD_BEEF; tvalid = 1; step(3); tvalid = 0;
      gen_en = 0; step(1);
      for (int i = 0; i < 3; i++) push(pat(i, 77), i == 2);
      push(pat(20, 5), 0);
      push(pat(21, 5), 0);
      addr_clr = 1; step(1); addr_clr = 0;
      cfg_div = 2; gen_en = 1;
      step(20);
      addr_clr = 1; step(1); addr_clr = 0;
      step(8);
      gen_en = 0;
      step(3);

      summary();
      $finish;
   end
endmodule